// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

The block is a small sum-of-products array whose connections come from a bank of fuse bits. It evaluates a fixed set of inputs into a fixed set of outputs and supports two topologies, chosen by a mode input. In the first, a programmable AND plane forms product terms, and each product term belongs to one output, which ORs its own terms together. In the second, a complete decoder produces one minterm for every input value, and a programmable OR plane chooses which minterms feed each output. Each input enters the array both as itself and as its complement.

The fuse bank is written one bit at a time through a load port while the program enable is high. Once loading ends, the fuses stay fixed and the array is purely combinational from the data inputs and the mode input to the outputs. A fuse value of 1 leaves its connection open. A fuse value of 0 makes the connection. Reset returns every fuse to the open state.

With the defaults there are 3 inputs, 4 outputs and 3 product terms per output. That gives 72 fuses in the AND-plane topology and 32 in the decoder topology. Both topologies share one 72-bit fuse bank, and the mode input decides how its bits are read.

Top module: `pla_array`

## Requirements
- R1: Input i appears on the AND plane as two literals: literal index 2*i carries the true value and literal index 2*i+1 carries the complement. Input bit 0 is input A, the least significant.
- R2: With `cfg_mode` = 0 (programmable AND), product term t of output o uses the fuses at address (o*TERMS_PER_OUT + t)*2*NUM_IN + literal. Output o is the OR of its own TERMS_PER_OUT terms and of no other terms.
- R3: With `cfg_mode` = 1 (fixed decoder), minterm k is true exactly when `data_in` equals k. Output o is the OR of every minterm k whose fuse at address o*2^NUM_IN + k is connected.
- R4: A fuse bit of 1 leaves its literal or minterm disconnected. A fuse bit of 0 connects it.
- R5: A product term with both polarities of any input connected is always 0. A product term with all of its fuses open is always 1.
- R6: In decoder mode, an output with every one of its minterm fuses open drives 0.
- R7: At a rising clock edge with `prog_en` high, `prog_data` is stored into the fuse at `prog_addr`, and writes to addresses at or beyond the fuse count are dropped. With `prog_en` low, the address and data inputs change no fuse.
- R8: While `prog_en` is high, every output is driven to 0.
- R9: A rising clock edge with `rst_n` low sets every fuse to 1. After reset, AND-plane mode therefore drives all outputs to 1 and decoder mode drives all outputs to 0.
- R10: Outside programming, the outputs follow changes on `data_in` and `cfg_mode` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fuse load port |
| rst_n | input | 1 | Synchronous active-low reset; opens every fuse |
| prog_en | input | 1 | Fuse write enable; also forces the outputs to 0 |
| prog_addr | input | 7 | Fuse bit address |
| prog_data | input | 1 | Fuse value to store (1 open, 0 connected) |
| cfg_mode | input | 1 | 0 programmable AND / fixed OR, 1 fixed decoder / programmable OR |
| data_in | input | 3 | Array inputs, bit 0 is input A |
| sum_out | output | 4 | OR-plane results |

## Verification
The assertions assume that the load inputs and `data_in` carry known values whenever reset is inactive. They also assume that reset is held across the first clock edge, so the fuse bank starts from its erased state. The bench drives every input from time zero and holds reset low across the first edges. It changes `prog_en`, `prog_addr` and `prog_data` only at falling edges, so each write falls on exactly one rising edge. Combinational results are sampled a few nanoseconds after an input change, while `prog_en` is low.

// File: rtl/pla_pkg.sv
// Package: types and helpers shared by the logic array.
// Assumes: nothing beyond elaboration-time integer arithmetic.
package pla_pkg;

    // Array topology selected at run time.
    typedef enum logic {
        MODE_PROG_AND  = 1'b0,   // programmable AND, fixed OR groups
        MODE_FIXED_AND = 1'b1    // full decoder, programmable OR
    } pla_mode_e;

    // Larger of two elaboration constants.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pla_fuse_bank.sv
// Module: flat bank of fuse bits written one bit per clock.
// Assumes: prog_addr is known whenever prog_en is high; out-of-range
// addresses are dropped; reset erases every bit to 1 (open).
module pla_fuse_bank #(
    parameter int FUSE_BITS = 72,
    parameter int ADDR_W    = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prog_en,
    input  logic [ADDR_W-1:0]    prog_addr,
    input  logic                 prog_data,
    output logic [FUSE_BITS-1:0] fuse_q
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(FUSE_BITS);

    logic addr_ok;

    // Address lies inside the bank.
    assign addr_ok = ({1'b0, prog_addr} < LIMIT);

    // Erase on reset, otherwise store one bit per enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fuse_q <= '1;
        end else if (prog_en && addr_ok) begin
            fuse_q[prog_addr] <= prog_data;
        end
    end

endmodule

// File: rtl/pla_and_plane.sv
// Module: programmable AND plane; each term ANDs the literals whose fuse is 0.
// Assumes: fuse 1 = open (literal forced to 1), fuse 0 = literal connected.
module pla_and_plane #(
    parameter int NUM_IN   = 3,
    parameter int NUM_TERM = 12
) (
    input  logic [2*NUM_IN-1:0]          lits,
    input  logic [NUM_TERM*2*NUM_IN-1:0] fuse,
    output logic [NUM_TERM-1:0]          term
);

    localparam int LIT = 2 * NUM_IN;

    // One AND gate per product term.
    for (genvar p = 0; p < NUM_TERM; p++) begin : g_term
        assign term[p] = &(lits | fuse[p*LIT +: LIT]);
    end

endmodule

// File: rtl/pla_decoder.sv
// Module: fixed AND plane as a full decoder producing all 2^N minterms.
// Assumes: data_in bit 0 is the least significant selector.
module pla_decoder #(
    parameter int NUM_IN = 3
) (
    input  logic [NUM_IN-1:0]     data_in,
    output logic [2**NUM_IN-1:0]  minterm
);

    // Minterm k is high exactly for input value k.
    for (genvar k = 0; k < 2**NUM_IN; k++) begin : g_mt
        assign minterm[k] = (data_in == NUM_IN'(k));
    end

endmodule

// File: rtl/pla_or_stage.sv
// Module: output stage holding the fixed OR groups and the programmable
// OR plane, with topology selection and output gating during programming.
// Assumes: terms are grouped per output, output o owning TERMS_PER_OUT terms.
module pla_or_stage
    import pla_pkg::*;
#(
    parameter int NUM_IN        = 3,
    parameter int NUM_OUT       = 4,
    parameter int TERMS_PER_OUT = 3
) (
    input  pla_mode_e                         mode,
    input  logic                              prog_en,
    input  logic [NUM_OUT*TERMS_PER_OUT-1:0]  term,
    input  logic [2**NUM_IN-1:0]              minterm,
    input  logic [NUM_OUT*(2**NUM_IN)-1:0]    or_fuse,
    output logic [NUM_OUT-1:0]                sum_out
);

    localparam int MT = 2 ** NUM_IN;

    logic [NUM_OUT-1:0] group_sum;
    logic [NUM_OUT-1:0] plane_sum;

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        // Fixed OR over the terms dedicated to this output.
        assign group_sum[o] = |term[o*TERMS_PER_OUT +: TERMS_PER_OUT];
        // Programmable OR over the connected minterms.
        assign plane_sum[o] = |(minterm & ~or_fuse[o*MT +: MT]);
    end

    // Pick the topology; hold outputs low while fuses are being written.
    always_comb begin
        if (prog_en) begin
            sum_out = '0;
        end else if (mode == MODE_FIXED_AND) begin
            sum_out = plane_sum;
        end else begin
            sum_out = group_sum;
        end
    end

endmodule

// File: rtl/pla_array.sv
// Module: top of the fuse-configured sum-of-products array.
// Assumes: fuses are loaded with prog_en high before use; outputs are
// combinational from data_in and cfg_mode once loading has ended.
module pla_array
    import pla_pkg::*;
#(
    parameter  int NUM_IN        = 3,
    parameter  int NUM_OUT       = 4,
    parameter  int TERMS_PER_OUT = 3,
    localparam int NUM_TERM      = NUM_OUT * TERMS_PER_OUT,
    localparam int AND_FUSES     = NUM_TERM * 2 * NUM_IN,
    localparam int OR_FUSES      = NUM_OUT * (2 ** NUM_IN),
    localparam int FUSE_BITS     = max_int(AND_FUSES, OR_FUSES),
    localparam int ADDR_W        = $clog2(FUSE_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_en,
    input  logic [ADDR_W-1:0]  prog_addr,
    input  logic               prog_data,
    input  logic               cfg_mode,
    input  logic [NUM_IN-1:0]  data_in,
    output logic [NUM_OUT-1:0] sum_out
);

    pla_mode_e                 mode;
    logic [FUSE_BITS-1:0]      fuse_q;
    logic [2*NUM_IN-1:0]       lits;
    logic [NUM_TERM-1:0]       term;
    logic [2**NUM_IN-1:0]      minterm;

    // Decode the topology select.
    assign mode = pla_mode_e'(cfg_mode);

    // True and complemented literal for every input.
    for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
        assign lits[2*i]   = data_in[i];
        assign lits[2*i+1] = ~data_in[i];
    end

    pla_fuse_bank #(
        .FUSE_BITS (FUSE_BITS),
        .ADDR_W    (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .fuse_q    (fuse_q)
    );

    pla_and_plane #(
        .NUM_IN   (NUM_IN),
        .NUM_TERM (NUM_TERM)
    ) u_and (
        .lits (lits),
        .fuse (fuse_q[AND_FUSES-1:0]),
        .term (term)
    );

    pla_decoder #(
        .NUM_IN (NUM_IN)
    ) u_dec (
        .data_in (data_in),
        .minterm (minterm)
    );

    pla_or_stage #(
        .NUM_IN        (NUM_IN),
        .NUM_OUT       (NUM_OUT),
        .TERMS_PER_OUT (TERMS_PER_OUT)
    ) u_or (
        .mode    (mode),
        .prog_en (prog_en),
        .term    (term),
        .minterm (minterm),
        .or_fuse (fuse_q[OR_FUSES-1:0]),
        .sum_out (sum_out)
    );

endmodule

// File: rtl/pla_array_chk.sv
// Checker: temporal properties of the logic array, bound to its top.
// Assumes: reset is applied before the first programming cycle.
module pla_array_chk #(
    parameter int NUM_IN    = 3,
    parameter int NUM_OUT   = 4,
    parameter int FUSE_BITS = 72,
    parameter int OR_FUSES  = 32,
    parameter int ADDR_W    = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 prog_en,
    input logic [ADDR_W-1:0]    prog_addr,
    input logic                 prog_data,
    input logic                 cfg_mode,
    input logic [NUM_OUT-1:0]   sum_out,
    input logic [FUSE_BITS-1:0] fuse_q,
    input logic [2**NUM_IN-1:0] minterm
);

    logic in_range;
    assign in_range = ({1'b0, prog_addr} < (ADDR_W+1)'(FUSE_BITS));

    AST_PROG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && in_range) |=> (fuse_q[$past(prog_addr)] == $past(prog_data))); // R7
    AST_FUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> $stable(fuse_q)); // R7
    AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> (sum_out == '0)); // R8
    AST_RESET_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&fuse_q)); // R9
    AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(minterm) == 1); // R3
    AST_EMPTY_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && !prog_en && (&fuse_q[OR_FUSES-1:0])) |-> (sum_out == '0)); // R6

endmodule

bind pla_array pla_array_chk #(
    .NUM_IN    (NUM_IN),
    .NUM_OUT   (NUM_OUT),
    .FUSE_BITS (FUSE_BITS),
    .OR_FUSES  (OR_FUSES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en   (prog_en),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .cfg_mode  (cfg_mode),
    .sum_out   (sum_out),
    .fuse_q    (fuse_q),
    .minterm   (minterm)
);

// File: tb/pla_array_tb.sv
// Directed bench for the logic array: one task per scenario.
module pla_array_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_en = 1'b0;
    logic [6:0] prog_addr = '0;
    logic       prog_data = 1'b1;
    logic       cfg_mode = 1'b0;
    logic [2:0] data_in = '0;
    logic [3:0] sum_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    pla_array u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .cfg_mode  (cfg_mode),
        .data_in   (data_in),
        .sum_out   (sum_out)
    );

    // AND-plane fuse address: output o, term t, literal l (R2).
    function automatic logic [6:0] and_addr(int o, int t, int l);
        return 7'((o * 3 + t) * 6 + l);
    endfunction

    // OR-plane fuse address: output o, minterm k (R3).
    function automatic logic [6:0] or_addr(int o, int k);
        return 7'(o * 8 + k);
    endfunction

    task automatic check(string req, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: sum_out=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        prog_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write one fuse bit over exactly one rising edge (R7).
    task automatic write_fuse(logic [6:0] addr, logic val);
        @(negedge clk);
        prog_en   = 1'b1;
        prog_addr = addr;
        prog_data = val;
        @(negedge clk);
        prog_en = 1'b0;
    endtask

    // Erased bank: AND mode all ones, decoder mode all zeros.
    task automatic t_reset_state();
        do_reset();
        cfg_mode = 1'b0;
        data_in  = 3'd5;
        #2;
        check("R9 erased AND mode", sum_out, 4'hF);
        cfg_mode = 1'b1;
        #2;
        check("R9 erased decoder mode", sum_out, 4'h0);
    endtask

    // Outputs held low while the write port is active.
    task automatic t_prog_quiet();
        do_reset();
        cfg_mode = 1'b0;
        @(negedge clk);
        prog_en   = 1'b1;
        prog_addr = 7'd127;   // beyond the bank, dropped
        prog_data = 1'b0;
        #2;
        check("R8 outputs low during programming", sum_out, 4'h0);
        @(negedge clk);
        prog_en = 1'b0;
        #2;
        check("R8 outputs released after programming", sum_out, 4'hF);
    endtask

    // Decoder mode: out0 odd parity, out1 value 0, out2 value>=6, out3 empty.
    task automatic t_decoder_mode();
        logic [3:0] exp;
        do_reset();
        cfg_mode = 1'b1;
        write_fuse(or_addr(0, 1), 1'b0);
        write_fuse(or_addr(0, 2), 1'b0);
        write_fuse(or_addr(0, 4), 1'b0);
        write_fuse(or_addr(0, 7), 1'b0);
        write_fuse(or_addr(1, 0), 1'b0);
        write_fuse(or_addr(2, 6), 1'b0);
        write_fuse(or_addr(2, 7), 1'b0);
        for (int k = 0; k < 8; k++) begin
            data_in = 3'(k);
            #2;
            exp[0] = ^data_in;
            exp[1] = (k == 0);
            exp[2] = (k >= 6);
            exp[3] = 1'b0;
            check("R3 R4 R6 decoder mode minterm select", sum_out, exp);
        end
    endtask

    // AND mode: out0=A&~B|C, out1 all contradicting, out2 open, out3=~A~B~C.
    task automatic t_and_mode();
        logic [3:0] exp;
        logic a, b, c;
        do_reset();
        cfg_mode = 1'b0;
        write_fuse(and_addr(0, 0, 0), 1'b0);
        write_fuse(and_addr(0, 0, 3), 1'b0);
        write_fuse(and_addr(0, 1, 4), 1'b0);
        write_fuse(and_addr(0, 2, 0), 1'b0);
        write_fuse(and_addr(0, 2, 1), 1'b0);
        for (int t = 0; t < 3; t++) begin
            write_fuse(and_addr(1, t, 0), 1'b0);
            write_fuse(and_addr(1, t, 1), 1'b0);
        end
        write_fuse(and_addr(3, 0, 1), 1'b0);
        write_fuse(and_addr(3, 0, 3), 1'b0);
        write_fuse(and_addr(3, 0, 5), 1'b0);
        for (int t = 1; t < 3; t++) begin
            write_fuse(and_addr(3, t, 0), 1'b0);
            write_fuse(and_addr(3, t, 1), 1'b0);
        end
        for (int k = 0; k < 8; k++) begin
            data_in = 3'(k);
            #2;
            a = data_in[0];
            b = data_in[1];
            c = data_in[2];
            exp[0] = (a & ~b) | c;
            exp[1] = 1'b0;
            exp[2] = 1'b1;
            exp[3] = ~a & ~b & ~c;
            check("R1 R2 R5 AND mode product terms", sum_out, exp);
        end
    endtask

    // Load inputs toggled with prog_en low change nothing.
    task automatic t_write_gated();
        @(negedge clk);
        prog_addr = and_addr(0, 0, 3);   // would drop ~B from out0 term0
        prog_data = 1'b1;
        repeat (2) @(negedge clk);
        data_in = 3'b011;                // A=1, B=1, C=0
        #2;
        check("R7 no write without prog_en", sum_out, 4'b0100);
    endtask

    // Outputs follow inputs and mode without a clock edge.
    task automatic t_comb_path();
        @(posedge clk);
        #1;
        data_in = 3'b001;                // A=1: out0=1, out2=1
        #1;
        check("R10 AND mode follows input", sum_out, 4'b0101);
        cfg_mode = 1'b1;                 // bank now holds AND-mode fuses
        data_in  = 3'b000;
        #1;
        // decoder read of AND bank: out0 minterm0 fuse addr0 = 0 (connected)
        check("R10 mode change takes effect", sum_out[0], 1'b1);
    endtask

    initial begin
        t_reset_state();
        t_prog_quiet();
        t_decoder_mode();
        t_and_mode();
        t_write_gated();
        t_comb_path();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule